// File: doc/BRIEF.md
# Byte-Lane Controller for Asynchronous Static RAM

This block sits between a clocked requester and an external asynchronous static RAM of 256K words by 32 bits. The RAM has four active-low lane enables, one shared write strobe, one shared output enable, an 18-bit address and a single 32-bit bidirectional data bus. The requester presents an address, a write flag, write data and a 4-bit lane mask through a ready/valid handshake. The controller then runs one complete memory cycle and reports completion with a one-cycle done pulse, which also carries the read data for reads.

The pin timing comes from elaboration-time cycle counts: access wait for reads, and setup, strobe width and hold for writes. Every access ends in a bus-turnaround phase. In that phase all lanes are deselected and the data driver is released, so the controller's driver and the memory's outputs never overlap, whichever way the bus changes direction. All pin outputs are taken straight from flops, so the write strobe and the enables cannot glitch. Only the lanes named in the mask are enabled, which makes partial writes and partial reads plain mask values.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `sram_ce_n` is 4'b1111, `sram_we_n` is 1, `sram_oe_n` is 1, `rsp_done` is 0 and `req_ready` is 1.
- R2: A request is taken only at a clock edge where both `req_valid` and `req_ready` are high. `req_ready` then stays low until the access, including its turnaround, has finished. It rises `L + TURN_CYC` cycles after the accepting edge, where L is the access length given in R3 or R5.
- R3: A read holds `sram_oe_n` low, `sram_we_n` high and `sram_ce_n` equal to the inverted mask for `RD_WAIT_CYC + 1` cycles. Bit i of the mask selects byte lane i, which is data bits `8i+7..8i`. The address is held on `sram_addr` for the whole access, and `rsp_done` pulses for one cycle `L = RD_WAIT_CYC + 1` cycles after the accepting edge.
- R4: When `rsp_done` pulses after a read, byte i of `rsp_rdata` equals byte i of the addressed word if mask bit i is set, and is zero otherwise.
- R5: A write holds `sram_ce_n` equal to the inverted mask and `sram_oe_n` high for `L = WR_LEAD_CYC + WR_STROBE_CYC + WR_TRAIL_CYC` cycles. `sram_we_n` is low for exactly `WR_STROBE_CYC` cycles, starting after `WR_LEAD_CYC` cycles, and `rsp_done` pulses for one cycle L cycles after the accepting edge.
- R6: During a write, the selected lanes of `sram_dq` carry the request's data, and `sram_addr` carries the request's address, from the first setup cycle through the last hold cycle. Both are therefore stable across the rising edge of `sram_we_n`.
- R7: `sram_oe_n` is never low while the controller drives any lane of `sram_dq`, and `sram_we_n` is never low while `sram_oe_n` is low.
- R8: After each access there are `TURN_CYC` cycles with `sram_ce_n` equal to 4'b1111, both strobes high and the controller's driver released, before `req_ready` rises again.
- R9: A write changes only the bytes of the addressed word whose mask bits are set. A write with mask 4'b0000 asserts no lane enable and changes no byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 32 | Write data |
| req_mask | input | 4 | Byte-lane select, bit i = lane i |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, unselected lanes zero |
| sram_addr | output | 18 | Memory address pins |
| sram_ce_n | output | 4 | Active-low per-lane enables |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq | inout | 32 | Bidirectional data bus |

## Verification
All sixteen lane masks are swept for writes to distinct words. Each write is read back three ways: with a full mask, with its own mask and with the complementary mask. The full-mask read shows whether unselected bytes kept their old contents. The other two reads show whether lane zeroing follows the mask rather than the data. Back-to-back write-to-read and read-to-write pairs on the same and on neighbouring words exercise both turnaround directions. Pin waveforms are compared cycle by cycle, so an access phase that is one cycle too long or too short is caught.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_RD_WAIT   = 3'd1,
      ST_RD_LATCH  = 3'd2,
      ST_WR_LEAD   = 3'd3,
      ST_WR_STROBE = 3'd4,
      ST_WR_TRAIL  = 3'd5,
      ST_BUS_TURN  = 3'd6
   } ctrl_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W        = 18,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned LANES         = 4,
   parameter int unsigned RD_WAIT_CYC   = 3,
   parameter int unsigned WR_LEAD_CYC   = 1,
   parameter int unsigned WR_STROBE_CYC = 2,
   parameter int unsigned WR_TRAIL_CYC  = 1,
   parameter int unsigned TURN_CYC      = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_mask,
   output logic              req_ready,
   output ctrl_state_e       state_q,
   output ctrl_state_e       state_d,
   output logic              dwell_done,
   output logic [ADDR_W-1:0] op_addr_d,
   output logic [DATA_W-1:0] op_wdata_d,
   output logic [LANES-1:0]  op_mask_d,
   output logic [LANES-1:0]  op_mask_q
);

   localparam int unsigned MAX_DWELL = max2(max2(RD_WAIT_CYC, WR_LEAD_CYC),
                                            max2(max2(WR_STROBE_CYC, WR_TRAIL_CYC), TURN_CYC));
   localparam int unsigned CNT_W = $clog2(MAX_DWELL + 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] op_addr_q;
   logic [DATA_W-1:0] op_wdata_q;
   logic              accept;

   function automatic logic [CNT_W-1:0] dwell_load(input ctrl_state_e s);
      case (s)
         ST_RD_WAIT:   dwell_load = CNT_W'(RD_WAIT_CYC - 1);
         ST_WR_LEAD:   dwell_load = CNT_W'(WR_LEAD_CYC - 1);
         ST_WR_STROBE: dwell_load = CNT_W'(WR_STROBE_CYC - 1);
         ST_WR_TRAIL:  dwell_load = CNT_W'(WR_TRAIL_CYC - 1);
         ST_BUS_TURN:  dwell_load = CNT_W'(TURN_CYC - 1);
         default:      dwell_load = '0;
      endcase
   endfunction

   assign req_ready  = (state_q == ST_IDLE);
   assign accept     = req_ready && req_valid;
   assign dwell_done = (cnt_q == '0);

   assign op_addr_d  = accept ? req_addr  : op_addr_q;
   assign op_wdata_d = accept ? req_wdata : op_wdata_q;
   assign op_mask_d  = accept ? req_mask  : op_mask_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:      if (req_valid) state_d = req_write ? ST_WR_LEAD : ST_RD_WAIT;
         ST_RD_WAIT:   if (dwell_done) state_d = ST_RD_LATCH;
         ST_RD_LATCH:  state_d = ST_BUS_TURN;
         ST_WR_LEAD:   if (dwell_done) state_d = ST_WR_STROBE;
         ST_WR_STROBE: if (dwell_done) state_d = ST_WR_TRAIL;
         ST_WR_TRAIL:  if (dwell_done) state_d = ST_BUS_TURN;
         ST_BUS_TURN:  if (dwell_done) state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cnt_q      <= '0;
         op_addr_q  <= '0;
         op_wdata_q <= '0;
         op_mask_q  <= '0;
      end else begin
         state_q    <= state_d;
         op_addr_q  <= op_addr_d;
         op_wdata_q <= op_wdata_d;
         op_mask_q  <= op_mask_d;
         if (state_d != state_q)
            cnt_q <= dwell_load(state_d);
         else if (!dwell_done)
            cnt_q <= cnt_q - 1'b1;
      end
   end

   p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_idle_only_after_turn_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && $past(state_q) != ST_IDLE) |-> $past(state_q) == ST_BUS_TURN);

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W       = 18,
   parameter int unsigned LANES        = 4,
   parameter int unsigned LANE_W       = 8,
   parameter bit          WR_DRIVE_ALL = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  ctrl_state_e             state_d,
   input  logic [ADDR_W-1:0]       op_addr_d,
   input  logic [LANES*LANE_W-1:0] op_wdata_d,
   input  logic [LANES-1:0]        op_mask_d,
   output logic [ADDR_W-1:0]       sram_addr,
   output logic [LANES-1:0]        sram_ce_n,
   output logic                    sram_we_n,
   output logic                    sram_oe_n,
   inout  wire  [LANES*LANE_W-1:0] sram_dq
);

   localparam int unsigned DATA_W = LANES * LANE_W;

   logic [LANES-1:0]  ce_n_nxt, ce_n_q;
   logic [LANES-1:0]  drv_nxt, drv_q;
   logic [LANES-1:0]  wr_lanes;
   logic              we_n_nxt, we_n_q;
   logic              oe_n_nxt, oe_n_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   generate
      if (WR_DRIVE_ALL) begin : g_drive_all
         assign wr_lanes = '1;
      end else begin : g_drive_sel
         assign wr_lanes = op_mask_d;
      end
   endgenerate

   always_comb begin
      ce_n_nxt = '1;
      drv_nxt  = '0;
      we_n_nxt = 1'b1;
      oe_n_nxt = 1'b1;
      case (state_d)
         ST_RD_WAIT, ST_RD_LATCH: begin
            ce_n_nxt = ~op_mask_d;
            oe_n_nxt = 1'b0;
         end
         ST_WR_LEAD, ST_WR_TRAIL: begin
            ce_n_nxt = ~op_mask_d;
            drv_nxt  = wr_lanes;
         end
         ST_WR_STROBE: begin
            ce_n_nxt = ~op_mask_d;
            drv_nxt  = wr_lanes;
            we_n_nxt = 1'b0;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ce_n_q  <= '1;
         drv_q   <= '0;
         we_n_q  <= 1'b1;
         oe_n_q  <= 1'b1;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         ce_n_q  <= ce_n_nxt;
         drv_q   <= drv_nxt;
         we_n_q  <= we_n_nxt;
         oe_n_q  <= oe_n_nxt;
         addr_q  <= op_addr_d;
         wdata_q <= op_wdata_d;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane_drv
      assign sram_dq[l*LANE_W +: LANE_W] = drv_q[l] ? wdata_q[l*LANE_W +: LANE_W] : {LANE_W{1'bz}};
   end

   assign sram_addr = addr_q;
   assign sram_ce_n = ce_n_q;
   assign sram_we_n = we_n_q;
   assign sram_oe_n = oe_n_q;

   p_no_drive_under_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n_q && (drv_q != '0)));

   p_strobe_excludes_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n_q |-> oe_n_q);

   p_addr_steady_in_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n_q && !$past(we_n_q)) |-> $stable(addr_q));

   p_data_held_past_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n_q) |-> ($stable(wdata_q) && $stable(addr_q) && (drv_q == $past(drv_q))));

endmodule

// File: rtl/sram_ctrl_resp.sv
module sram_ctrl_resp
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  ctrl_state_e             state_q,
   input  logic                    dwell_done,
   input  logic [LANES-1:0]        op_mask_q,
   input  logic [LANES*LANE_W-1:0] bus_in,
   output logic                    rsp_done,
   output logic [LANES*LANE_W-1:0] rsp_rdata
);

   localparam int unsigned DATA_W = LANES * LANE_W;

   logic [DATA_W-1:0] lane_keep;
   logic [DATA_W-1:0] rdata_q;
   logic              done_q;
   logic              capture;

   for (genvar l = 0; l < LANES; l++) begin : g_keep
      assign lane_keep[l*LANE_W +: LANE_W] = {LANE_W{op_mask_q[l]}};
   end

   assign capture = (state_q == ST_RD_LATCH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= capture || ((state_q == ST_WR_TRAIL) && dwell_done);
         if (capture)
            rdata_q <= bus_in & lane_keep;
      end
   end

   assign rsp_done  = done_q;
   assign rsp_rdata = rdata_q;

   p_done_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   p_rdata_lanes_zeroed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && $past(capture)) |-> ((rsp_rdata & ~$past(lane_keep)) == '0));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W        = 18,
   parameter int unsigned LANES         = 4,
   parameter int unsigned LANE_W        = 8,
   parameter int unsigned RD_WAIT_CYC   = 3,
   parameter int unsigned WR_LEAD_CYC   = 1,
   parameter int unsigned WR_STROBE_CYC = 2,
   parameter int unsigned WR_TRAIL_CYC  = 1,
   parameter int unsigned TURN_CYC      = 1,
   parameter bit          WR_DRIVE_ALL  = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    req_write,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [LANES*LANE_W-1:0] req_wdata,
   input  logic [LANES-1:0]        req_mask,
   output logic                    rsp_done,
   output logic [LANES*LANE_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0]       sram_addr,
   output logic [LANES-1:0]        sram_ce_n,
   output logic                    sram_we_n,
   output logic                    sram_oe_n,
   inout  wire  [LANES*LANE_W-1:0] sram_dq
);

   localparam int unsigned DATA_W = LANES * LANE_W;

   generate
      if (ADDR_W < 1 || LANES < 1 || LANE_W < 1) begin : g_bad_shape
         $error("sram_lane_ctrl: address, lane count and lane width must be nonzero");
      end
      if (RD_WAIT_CYC < 1 || WR_LEAD_CYC < 1 || WR_STROBE_CYC < 1) begin : g_bad_access
         $error("sram_lane_ctrl: access wait, write setup and strobe need at least one cycle");
      end
      if (WR_TRAIL_CYC < 1 || TURN_CYC < 1) begin : g_bad_release
         $error("sram_lane_ctrl: write hold and turnaround need at least one cycle");
      end
   endgenerate

   ctrl_state_e       state_q, state_d;
   logic              dwell_done;
   logic [ADDR_W-1:0] op_addr_d;
   logic [DATA_W-1:0] op_wdata_d;
   logic [LANES-1:0]  op_mask_d, op_mask_q;

   sram_ctrl_fsm #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES),
      .RD_WAIT_CYC(RD_WAIT_CYC), .WR_LEAD_CYC(WR_LEAD_CYC),
      .WR_STROBE_CYC(WR_STROBE_CYC), .WR_TRAIL_CYC(WR_TRAIL_CYC),
      .TURN_CYC(TURN_CYC)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_mask(req_mask), .req_ready(req_ready),
      .state_q(state_q), .state_d(state_d), .dwell_done(dwell_done),
      .op_addr_d(op_addr_d), .op_wdata_d(op_wdata_d),
      .op_mask_d(op_mask_d), .op_mask_q(op_mask_q)
   );

   sram_ctrl_pins #(
      .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .WR_DRIVE_ALL(WR_DRIVE_ALL)
   ) u_pins (
      .clk(clk), .rst_n(rst_n), .state_d(state_d),
      .op_addr_d(op_addr_d), .op_wdata_d(op_wdata_d), .op_mask_d(op_mask_d),
      .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
      .sram_oe_n(sram_oe_n), .sram_dq(sram_dq)
   );

   sram_ctrl_resp #(
      .LANES(LANES), .LANE_W(LANE_W)
   ) u_resp (
      .clk(clk), .rst_n(rst_n), .state_q(state_q), .dwell_done(dwell_done),
      .op_mask_q(op_mask_q), .bus_in(sram_dq),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
   );

   p_lanes_follow_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (sram_we_n && sram_oe_n));

endmodule

// File: tb/tb_sram_lane_ctrl.sv
`timescale 1ns/1ps
module tb_sram_lane_ctrl;

   localparam int RD  = 2;
   localparam int WS  = 1;
   localparam int WP  = 3;
   localparam int WH  = 1;
   localparam int TRN = 2;
   localparam int WDOG = 20000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write;
   logic        req_ready;
   logic [17:0] req_addr;
   logic [31:0] req_wdata;
   logic [3:0]  req_mask;
   logic        rsp_done;
   logic [31:0] rsp_rdata;
   logic [17:0] sram_addr;
   logic [3:0]  sram_ce_n;
   logic        sram_we_n, sram_oe_n;
   wire  [31:0] sram_dq;

   int n_vec = 0;
   int n_bad = 0;
   bit ended = 1'b0;

   logic [31:0] mdl_mem [0:63];
   logic [31:0] exp_mem [0:63];
   int          we_low_cnt;

   always #2 clk = ~clk;

   sram_lane_ctrl #(
      .RD_WAIT_CYC(RD), .WR_LEAD_CYC(WS), .WR_STROBE_CYC(WP),
      .WR_TRAIL_CYC(WH), .TURN_CYC(TRN)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_mask(req_mask), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
      .sram_oe_n(sram_oe_n), .sram_dq(sram_dq)
   );

   // Behavioural memory: a lane drives when enabled, read-selected and not written.
   for (genvar l = 0; l < 4; l++) begin : g_mdl
      assign sram_dq[l*8 +: 8] = (!sram_ce_n[l] && !sram_oe_n && sram_we_n) ?
                                 mdl_mem[sram_addr[5:0]][l*8 +: 8] : 8'bz;
   end

   function automatic logic [31:0] init_word(input int i);
      return 32'h1000_0000 + i * 32'h0001_0203;
   endfunction

   function automatic logic [31:0] lane_bits(input logic [3:0] m);
      logic [31:0] r;
      for (int l = 0; l < 4; l++) r[l*8 +: 8] = {8{m[l]}};
      return r;
   endfunction

   initial begin
      for (int i = 0; i < 64; i++) mdl_mem[i] = init_word(i);
   end

   always @(posedge sram_we_n) begin
      if (rst_n) begin
         for (int l = 0; l < 4; l++)
            if (!sram_ce_n[l]) mdl_mem[sram_addr[5:0]][l*8 +: 8] = sram_dq[l*8 +: 8];
      end
   end

   always @(posedge clk) begin
      if (!sram_we_n) we_low_cnt <= we_low_cnt + 1;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   // One access; pins compared every cycle against the phase expected from the requirements.
   task automatic run_op(input bit wr, input logic [5:0] a, input logic [31:0] d, input logic [3:0] m);
      int          len;
      logic [7:0]  pin_exp, pin_act;
      logic [31:0] lm;
      bit          strobe, active;
      lm  = lane_bits(m);
      len = wr ? (WS + WP + WH) : (RD + 1);
      @(negedge clk);
      chk(req_ready, "R2 ready before request", {31'd0, req_ready}, 32'd1);
      req_valid = 1'b1; req_write = wr; req_addr = {12'd0, a}; req_wdata = d; req_mask = m;
      we_low_cnt = 0;
      for (int c = 1; c <= len + TRN + 1; c++) begin
         @(negedge clk);
         req_valid = 1'b0;
         req_wdata = ~d;
         req_addr  = 18'h3FFFF;
         active = (c <= len);
         strobe = wr && (c > WS) && (c <= WS + WP);
         pin_exp = {active ? ~m : 4'hF, ~strobe, ~(active && !wr), c == len + 1, c == len + TRN + 1};
         pin_act = {sram_ce_n, sram_we_n, sram_oe_n, rsp_done, req_ready};
         chk(pin_act == pin_exp, wr ? "R5 R8 write pins {ce,we,oe,done,ready}" :
                                      "R3 R8 read pins {ce,we,oe,done,ready}",
             {24'd0, pin_act}, {24'd0, pin_exp});
         if (active)
            chk(sram_addr == {12'd0, a}, "R3 R6 address held", {14'd0, sram_addr}, {26'd0, a});
         if (active && wr)
            chk((sram_dq & lm) == (d & lm), "R6 write data on bus", sram_dq & lm, d & lm);
         if (!wr && c == len + 1)
            chk(rsp_rdata == (exp_mem[a] & lm), "R4 read data lanes", rsp_rdata, exp_mem[a] & lm);
      end
      if (wr) begin
         exp_mem[a] = (exp_mem[a] & ~lm) | (d & lm);
         chk(we_low_cnt == WP, "R5 strobe width", we_low_cnt, WP);
         chk(mdl_mem[a] == exp_mem[a], "R9 memory after masked write", mdl_mem[a], exp_mem[a]);
      end
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_wdata = '0; req_mask = '0;
      we_low_cnt = 0;
      for (int i = 0; i < 64; i++) exp_mem[i] = init_word(i);
      repeat (3) @(negedge clk);
      chk({sram_ce_n, sram_we_n, sram_oe_n, rsp_done, req_ready} == 8'b1111_1101,
          "R1 pins in reset", {24'd0, sram_ce_n, sram_we_n, sram_oe_n, rsp_done, req_ready}, 32'hFD);
      rst_n = 1'b1;
      @(negedge clk);
      chk({sram_ce_n, sram_we_n, sram_oe_n, rsp_done, req_ready} == 8'b1111_1101,
          "R1 pins after reset", {24'd0, sram_ce_n, sram_we_n, sram_oe_n, rsp_done, req_ready}, 32'hFD);

      // Every mask written, then read full, own mask and complement (R4, R9).
      for (int m = 0; m < 16; m++) begin
         run_op(1'b1, 6'(2*m + 1), 32'h9E37_79B9 * (m + 1) ^ (m << 3), 4'(m));
         run_op(1'b0, 6'(2*m + 1), 32'h0, 4'hF);
         run_op(1'b0, 6'(2*m + 1), 32'h0, 4'(m));
      end
      for (int m = 0; m < 16; m++)
         run_op(1'b0, 6'(2*m + 1), 32'h0, 4'(~m));

      // Turnaround in both directions, same and neighbouring words (R7, R8).
      run_op(1'b1, 6'd40, 32'hDEAD_BEEF, 4'hF);
      run_op(1'b0, 6'd40, 32'h0, 4'hF);
      run_op(1'b1, 6'd41, 32'h0123_4567, 4'h5);
      run_op(1'b0, 6'd40, 32'h0, 4'hA);
      run_op(1'b0, 6'd41, 32'h0, 4'hF);
      run_op(1'b1, 6'd40, 32'hCAFE_F00D, 4'h9);
      run_op(1'b1, 6'd40, 32'h5555_AAAA, 4'h6);
      run_op(1'b0, 6'd40, 32'h0, 4'hF);
      run_op(1'b0, 6'd42, 32'h0, 4'h0);
      finish_run();
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      n_bad++;
      $display("FAIL R2 watchdog expired act=%0d exp=%0d", WDOG, 0);
      finish_run();
   end

endmodule